// File: doc/BRIEF.md
# Store Commit Queue

This block keeps the stores of an out-of-order core in program order between issue and the data cache. Each slot holds a store's address, data, byte count and sequence number. Three ring pointers walk the slots: the oldest live store (head), the next store to send (writeback pointer) and the next free slot (tail). The ring has one spare slot beyond its capacity, so a full queue and an empty queue never share the same pointer state.

A commit input marks stores as safe to write. The writeback engine takes marked stores strictly in order and puts one at a time on a valid/ready request channel. A store of zero bytes is finished on the spot and no request goes out for it. Once a request is accepted, the cache returns an acknowledge pulse carrying the slot index. Acknowledges may arrive in any order. The head then moves over every finished slot in a row in one step. A squash input removes uncommitted stores from the young end. A stall tag links a waiting load to one store, and when that store finishes the block emits a replay pulse with the load's index.

Back-pressure rules: a store enters only in a cycle where `alloc_valid` and `alloc_ready` are both high. Once `req_valid` rises, the request fields stay frozen until the cycle where `req_ready` is high, and then the request counts as accepted. A refused request is therefore re-offered unchanged, and nothing behind it is sent.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `req_valid` is 0, `replay_valid` is 0 and `free_slots` equals the smaller of `lq_free` and DEPTH.
- R2: The queue holds at most DEPTH stores and then drops `alloc_ready`. `alloc_idx` counts up through DEPTH+1 slot indices and wraps from DEPTH back to 0.
- R3: `free_slots` is the smaller of `lq_free` and (DEPTH minus stores held).
- R4: A commit with sequence C walks from the oldest store. It marks every store with sequence at most C and stops at the first unmarked store with sequence above C. An unmarked store is never sent, and a commit below the oldest sequence changes nothing.
- R5: Marked stores with a nonzero byte count are offered in program order, one at a time. `req_addr`, `req_data`, `req_size` and `req_idx` carry the store's fields and slot. A store marked at clock edge E is offered from edge E+1, and a new request may follow at the same edge that accepts the previous one.
- R6: While `req_valid` is 1 and `req_ready` is 0, all request fields hold and no other store is offered.
- R7: A marked store whose byte count is 0 is finished without any request, even while an earlier request waits on the port.
- R8: `wr_ack_valid` with `wr_ack_idx` finishes that slot. Slots are freed only from the head. One edge after a finishing event, the head passes every consecutive finished slot, so out-of-order acknowledges free nothing until the oldest one finishes.
- R9: `squash_valid` with sequence S removes, from the young end, stores with sequence above S. It stops at the first store already marked by a commit. `alloc_ready` is 0 during a squash, and the next store allocated after it reuses the first removed slot.
- R10: `stall_set` records a store sequence and a load index. One edge after the store with that sequence finishes (by acknowledge or as a zero-byte store), `replay_valid` is 1 for exactly one cycle with `replay_load_idx` equal to the recorded load index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Store offered for insertion |
| alloc_ready | output | 1 | Queue can take a store this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the offered store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store byte count, 0 means no memory access |
| alloc_idx | output | PTR_W | Slot the offered store will occupy |
| commit_valid | input | 1 | Commit pulse |
| commit_seq | input | SEQ_W | Youngest committed sequence |
| squash_valid | input | 1 | Squash pulse |
| squash_seq | input | SEQ_W | Youngest surviving sequence |
| req_valid | output | 1 | Cache write request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_size | output | SIZE_W | Request byte count |
| req_idx | output | PTR_W | Slot of the request, echoed on acknowledge |
| wr_ack_valid | input | 1 | Write acknowledge pulse |
| wr_ack_idx | input | PTR_W | Slot being acknowledged |
| stall_set | input | 1 | Record a stalling store for a waiting load |
| stall_seq | input | SEQ_W | Sequence of the stalling store |
| stall_load_idx | input | LQ_IDX_W | Index of the waiting load |
| replay_valid | output | 1 | Replay pulse for the waiting load |
| replay_load_idx | output | LQ_IDX_W | Load index to replay |
| lq_free | input | LQ_CNT_W | Free load slots |
| free_slots | output | CNT_W | Memory instructions that can still be accepted |

## Verification
The checker assumes the surrounding core keeps its contract. Sequence numbers rise in allocation order without wrapping. Acknowledges name only slots whose request was accepted, and each slot is acknowledged once. A squash never shares a cycle with an allocation or a commit, and no new stall is recorded in the cycle its store finishes. The stimulus allocates with increasing sequences. It pulses commit and squash in separate cycles, acknowledges only indices it has just seen accepted, and arms the stall tag well before the matching store is committed.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Forward step around a ring of n slots
  function automatic int ring_fwd(input int p, input int k, input int n);
    return (p + k) % n;
  endfunction

  // Backward step around a ring of n slots (k <= n)
  function automatic int ring_back(input int p, input int k, input int n);
    return (p - k + n) % n;
  endfunction

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_SKIP = 2'd1,
    WB_SEND = 2'd2
  } wb_action_e;

endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int PTR_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] occ,
  input  logic [SLOTS-1:0] canwb,
  input  logic [SEQ_W-1:0] seq [SLOTS],
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  output logic [SLOTS-1:0] mark
);

  always_comb begin
    logic halt;
    int   p;
    mark = '0;
    halt = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      p = ring_fwd(int'(head), k, SLOTS);
      if (commit_valid && !halt && (k < int'(occ))) begin
        if (!canwb[p]) begin
          if (seq[p] > commit_seq) halt = 1'b1;
          else                     mark[p] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int PTR_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic [PTR_W-1:0] tail,
  input  logic [PTR_W-1:0] occ,
  input  logic [SLOTS-1:0] canwb,
  input  logic [SEQ_W-1:0] seq [SLOTS],
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic [PTR_W-1:0] drop_cnt
);

  always_comb begin
    logic halt;
    int   p;
    int   n;
    halt = 1'b0;
    n    = 0;
    for (int k = 1; k < SLOTS; k++) begin
      p = ring_back(int'(tail), k, SLOTS);
      if (squash_valid && !halt && (k <= int'(occ))) begin
        if (canwb[p] || (seq[p] <= squash_seq)) halt = 1'b1;
        else                                    n = n + 1;
      end
    end
    drop_cnt = PTR_W'(n);
  end

endmodule

// File: rtl/sq_head_advance.sv
module sq_head_advance
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int PTR_W = 3
) (
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] occ,
  input  logic [SLOTS-1:0] done,
  output logic [PTR_W-1:0] adv_cnt
);

  always_comb begin
    logic halt;
    int   p;
    int   n;
    halt = 1'b0;
    n    = 0;
    for (int k = 0; k < SLOTS; k++) begin
      p = ring_fwd(int'(head), k, SLOTS);
      if (!halt && (k < int'(occ))) begin
        if (done[p]) n = n + 1;
        else         halt = 1'b1;
      end
    end
    adv_cnt = PTR_W'(n);
  end

endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue
  import sq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int SEQ_W    = 8,
  parameter int LQ_DEPTH = 8,
  localparam int SLOTS    = DEPTH + 1,
  localparam int PTR_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LQ_IDX_W = $clog2(LQ_DEPTH),
  localparam int LQ_CNT_W = $clog2(LQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic [ADDR_W-1:0]   alloc_addr,
  input  logic [DATA_W-1:0]   alloc_data,
  input  logic [SIZE_W-1:0]   alloc_size,
  output logic [PTR_W-1:0]    alloc_idx,
  input  logic                commit_valid,
  input  logic [SEQ_W-1:0]    commit_seq,
  input  logic                squash_valid,
  input  logic [SEQ_W-1:0]    squash_seq,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [DATA_W-1:0]   req_data,
  output logic [SIZE_W-1:0]   req_size,
  output logic [PTR_W-1:0]    req_idx,
  input  logic                wr_ack_valid,
  input  logic [PTR_W-1:0]    wr_ack_idx,
  input  logic                stall_set,
  input  logic [SEQ_W-1:0]    stall_seq,
  input  logic [LQ_IDX_W-1:0] stall_load_idx,
  output logic                replay_valid,
  output logic [LQ_IDX_W-1:0] replay_load_idx,
  input  logic [LQ_CNT_W-1:0] lq_free,
  output logic [CNT_W-1:0]    free_slots
);

  // Ring pointers
  logic [PTR_W-1:0] head_q, tail_q, wb_q;
  logic [PTR_W-1:0] occ;

  // Per-slot state, gathered from the slot generate below
  logic [SLOTS-1:0]  canwb_vec, done_vec;
  logic [ADDR_W-1:0] addr_a [SLOTS];
  logic [DATA_W-1:0] data_a [SLOTS];
  logic [SIZE_W-1:0] size_a [SLOTS];
  logic [SEQ_W-1:0]  seq_a  [SLOTS];

  // Scan results
  logic [SLOTS-1:0] mark;
  logic [PTR_W-1:0] drop_cnt, adv_cnt;

  // Writeback control
  logic             alloc_fire;
  logic             wb_has, port_free;
  wb_action_e       wb_act;
  logic             req_valid_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_data_q;
  logic [SIZE_W-1:0] req_size_q;
  logic [PTR_W-1:0]  req_idx_q;

  // Stall tracking
  logic                stall_armed_q;
  logic [SEQ_W-1:0]    stall_seq_q;
  logic [LQ_IDX_W-1:0] stall_ld_q;
  logic                stall_hit;
  logic                replay_q;
  logic [LQ_IDX_W-1:0] replay_idx_q;

  // Occupancy and free count
  always_comb begin
    int diff;
    diff = int'(tail_q) - int'(head_q);
    if (diff < 0) diff = diff + SLOTS;
    occ = PTR_W'(diff);
  end

  logic [CNT_W-1:0] sq_free;
  assign sq_free     = CNT_W'(DEPTH - int'(occ));
  assign free_slots  = (int'(lq_free) < int'(sq_free)) ? CNT_W'(lq_free) : sq_free;

  assign alloc_ready = (int'(occ) < DEPTH) && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;

  // Scanners
  sq_commit_scan #(.SLOTS(SLOTS), .PTR_W(PTR_W), .SEQ_W(SEQ_W)) u_commit (
    .head(head_q), .occ(occ), .canwb(canwb_vec), .seq(seq_a),
    .commit_valid(commit_valid), .commit_seq(commit_seq), .mark(mark)
  );

  sq_squash_scan #(.SLOTS(SLOTS), .PTR_W(PTR_W), .SEQ_W(SEQ_W)) u_squash (
    .tail(tail_q), .occ(occ), .canwb(canwb_vec), .seq(seq_a),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .drop_cnt(drop_cnt)
  );

  sq_head_advance #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_head (
    .head(head_q), .occ(occ), .done(done_vec), .adv_cnt(adv_cnt)
  );

  // Writeback decision for the slot under the writeback pointer
  assign wb_has    = (wb_q != tail_q) && canwb_vec[wb_q];
  assign port_free = !req_valid_q || req_ready;

  always_comb begin
    wb_act = WB_NONE;
    if (wb_has) begin
      if (size_a[wb_q] == '0) wb_act = WB_SKIP;
      else if (port_free)     wb_act = WB_SEND;
    end
  end

  // Per-slot storage and flags
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              cw_r, dn_r;
    logic [ADDR_W-1:0] a_r;
    logic [DATA_W-1:0] d_r;
    logic [SIZE_W-1:0] s_r;
    logic [SEQ_W-1:0]  q_r;
    logic              hit_alloc, hit_done;

    assign hit_alloc = alloc_fire && (tail_q == PTR_W'(g));
    assign hit_done  = (wr_ack_valid && (wr_ack_idx == PTR_W'(g))) ||
                       ((wb_act == WB_SKIP) && (wb_q == PTR_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cw_r <= 1'b0;
        dn_r <= 1'b0;
      end else if (hit_alloc) begin
        cw_r <= 1'b0;
        dn_r <= 1'b0;
      end else begin
        if (mark[g]) cw_r <= 1'b1;
        if (hit_done) dn_r <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        a_r <= alloc_addr;
        d_r <= alloc_data;
        s_r <= alloc_size;
        q_r <= alloc_seq;
      end
    end

    assign canwb_vec[g] = cw_r;
    assign done_vec[g]  = dn_r;
    assign addr_a[g]    = a_r;
    assign data_a[g]    = d_r;
    assign size_a[g]    = s_r;
    assign seq_a[g]     = q_r;
  end

  // Pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      wb_q   <= '0;
    end else begin
      head_q <= PTR_W'(ring_fwd(int'(head_q), int'(adv_cnt), SLOTS));
      if (squash_valid)
        tail_q <= PTR_W'(ring_back(int'(tail_q), int'(drop_cnt), SLOTS));
      else if (alloc_fire)
        tail_q <= PTR_W'(ring_fwd(int'(tail_q), 1, SLOTS));
      if (wb_act != WB_NONE)
        wb_q <= PTR_W'(ring_fwd(int'(wb_q), 1, SLOTS));
    end
  end

  // Request register: holds its fields until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid_q <= 1'b0;
      req_addr_q  <= '0;
      req_data_q  <= '0;
      req_size_q  <= '0;
      req_idx_q   <= '0;
    end else if (wb_act == WB_SEND) begin
      req_valid_q <= 1'b1;
      req_addr_q  <= addr_a[wb_q];
      req_data_q  <= data_a[wb_q];
      req_size_q  <= size_a[wb_q];
      req_idx_q   <= wb_q;
    end else if (req_ready) begin
      req_valid_q <= 1'b0;
    end
  end

  assign req_valid = req_valid_q;
  assign req_addr  = req_addr_q;
  assign req_data  = req_data_q;
  assign req_size  = req_size_q;
  assign req_idx   = req_idx_q;

  // Stalling-store match on any finishing event
  assign stall_hit = stall_armed_q &&
    ((wr_ack_valid && (seq_a[wr_ack_idx] == stall_seq_q)) ||
     ((wb_act == WB_SKIP) && (seq_a[wb_q] == stall_seq_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_armed_q <= 1'b0;
      stall_seq_q   <= '0;
      stall_ld_q    <= '0;
      replay_q      <= 1'b0;
      replay_idx_q  <= '0;
    end else begin
      replay_q <= stall_hit;
      if (stall_hit) begin
        replay_idx_q  <= stall_ld_q;
        stall_armed_q <= 1'b0;
      end
      if (stall_set) begin
        stall_armed_q <= 1'b1;
        stall_seq_q   <= stall_seq;
        stall_ld_q    <= stall_load_idx;
      end
    end
  end

  assign replay_valid    = replay_q;
  assign replay_load_idx = replay_idx_q;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic [SIZE_W-1:0] req_size,
  input logic [PTR_W-1:0]  req_idx,
  input logic [PTR_W-1:0]  occ,
  input logic [CNT_W-1:0]  free_slots,
  input logic              replay_valid
);

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_data) && $stable(req_size) && $stable(req_idx)));

  // R7
  nonzero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // R5
  distinct_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || (req_idx != $past(req_idx))));

  // R10
  replay_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |=> !replay_valid);

  // R3
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_slots) <= DEPTH);

endmodule

bind store_commit_queue sq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
  .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_sq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
  .req_idx(req_idx), .occ(occ), .free_slots(free_slots),
  .replay_valid(replay_valid)
);

// File: tb/sim_store_commit_queue.sv
`timescale 1ns/1ps
module sim_store_commit_queue;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [7:0]  alloc_seq = '0;
  logic [15:0] alloc_addr = '0;
  logic [31:0] alloc_data = '0;
  logic [3:0]  alloc_size = '0;
  logic [2:0]  alloc_idx;
  logic        commit_valid = 1'b0;
  logic [7:0]  commit_seq = '0;
  logic        squash_valid = 1'b0;
  logic [7:0]  squash_seq = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr;
  logic [31:0] req_data;
  logic [3:0]  req_size;
  logic [2:0]  req_idx;
  logic        wr_ack_valid = 1'b0;
  logic [2:0]  wr_ack_idx = '0;
  logic        stall_set = 1'b0;
  logic [7:0]  stall_seq = '0;
  logic [2:0]  stall_load_idx = '0;
  logic        replay_valid;
  logic [2:0]  replay_load_idx;
  logic [3:0]  lq_free = 4'd8;
  logic [2:0]  free_slots;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  store_commit_queue #(.DEPTH(DEPTH)) u0 (.*);

  // {addr, data, size}
  localparam logic [51:0] STIM [4] = '{
    {16'h0100, 32'hA0A0_0001, 4'd4},
    {16'h0204, 32'hB0B0_0002, 4'd0},
    {16'h0308, 32'hC0C0_0003, 4'd2},
    {16'h040C, 32'hD0D0_0004, 4'd1}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [7:0] s, input logic [51:0] v, input int exp_idx);
    alloc_valid = 1'b1; alloc_seq = s;
    {alloc_addr, alloc_data, alloc_size} = v;
    #1;
    chk(alloc_ready == 1'b1, "R2 alloc_ready", alloc_ready, 1);
    chk(int'(alloc_idx) == exp_idx, "R2 alloc_idx", alloc_idx, exp_idx);
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic pulse_commit(input logic [7:0] s);
    commit_valid = 1'b1; commit_seq = s;
    tick();
    commit_valid = 1'b0;
  endtask

  task automatic pulse_ack(input logic [2:0] i);
    wr_ack_valid = 1'b1; wr_ack_idx = i;
    tick();
    wr_ack_valid = 1'b0;
  endtask

  task automatic expect_req(input string tag, input int idx, input logic [51:0] v);
    chk(req_valid == 1'b1, tag, req_valid, 1);
    chk(int'(req_idx) == idx, tag, req_idx, idx);
    chk({req_addr, req_data, req_size} == v, tag, {req_addr, req_data, req_size}, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
    chk(replay_valid == 1'b0, "R1 replay_valid", replay_valid, 0);
    chk(free_slots == 3'd4, "R1 free_slots", free_slots, 4);

    // Table walk: fill the queue
    for (int i = 0; i < 4; i++) do_alloc(8'(10 + i), STIM[i], i);
    #1;
    chk(alloc_ready == 1'b0, "R2 full", alloc_ready, 0);
    chk(free_slots == 3'd0, "R3 full", free_slots, 0);
    tick(); tick();
    chk(req_valid == 1'b0, "R4 nothing committed", req_valid, 0);

    // Commit first two (second is zero-size)
    pulse_commit(8'd11);
    chk(req_valid == 1'b0, "R5 one edge latency", req_valid, 1'b0);
    tick();
    expect_req("R5 first req", 0, STIM[0]);
    tick(); tick();
    expect_req("R6 held under back-pressure", 0, STIM[0]);
    chk(free_slots == 3'd0, "R8 head blocked", free_slots, 0);
    req_ready = 1'b1;
    tick();
    chk(req_valid == 1'b0, "R4 R7 no request for zero-size or uncommitted", req_valid, 0);
    pulse_ack(3'd0);
    tick();
    chk(free_slots == 3'd2, "R8 R7 run of two freed", free_slots, 2);

    // Commit remaining, back-to-back requests in order
    pulse_commit(8'd13);
    tick();
    for (int i = 2; i < 4; i++) begin
      expect_req("R5 ordered req", i, STIM[i]);
      tick();
    end
    chk(req_valid == 1'b0, "R5 drained", req_valid, 0);

    // Out-of-order acknowledges
    pulse_ack(3'd3);
    tick();
    chk(free_slots == 3'd2, "R8 younger ack frees nothing", free_slots, 2);
    pulse_ack(3'd2);
    tick();
    chk(free_slots == 3'd4, "R8 both freed", free_slots, 4);
    lq_free = 4'd1; #1;
    chk(free_slots == 3'd1, "R3 load side smaller", free_slots, 1);
    lq_free = 4'd8;

    // Stall tag on a zero-size store at slot 4, then wrap to 0
    stall_set = 1'b1; stall_seq = 8'd20; stall_load_idx = 3'd5;
    tick();
    stall_set = 1'b0;
    do_alloc(8'd20, {16'h0500, 32'h0, 4'd0}, 4);
    #1;
    chk(alloc_idx == 3'd0, "R2 index wraps", alloc_idx, 0);
    pulse_commit(8'd20);
    chk(replay_valid == 1'b0, "R10 not yet", replay_valid, 0);
    tick();
    chk(replay_valid == 1'b1, "R10 replay pulse", replay_valid, 1);
    chk(replay_load_idx == 3'd5, "R10 load idx", replay_load_idx, 5);
    tick();
    chk(replay_valid == 1'b0, "R10 single pulse", replay_valid, 0);
    chk(free_slots == 3'd4, "R7 zero-size freed", free_slots, 4);

    // Squash stops at committed store
    req_ready = 1'b0;
    for (int i = 0; i < 4; i++)
      do_alloc(8'(30 + i), {16'(16'h0600 + i), 32'(32'hE000_0000 + i), 4'd4}, i);
    pulse_commit(8'd31);
    squash_valid = 1'b1; squash_seq = 8'd30;
    #1;
    chk(alloc_ready == 1'b0, "R9 no alloc during squash", alloc_ready, 0);
    tick();
    squash_valid = 1'b0;
    #1;
    chk(free_slots == 3'd2, "R9 two removed", free_slots, 2);
    expect_req("R9 committed survives", 0, {16'h0600, 32'hE000_0000, 4'd4});
    req_ready = 1'b1;
    tick();
    expect_req("R9 second survivor", 1, {16'h0601, 32'hE000_0001, 4'd4});
    tick();
    chk(req_valid == 1'b0, "R9 squashed never sent", req_valid, 0);
    pulse_ack(3'd0);
    pulse_ack(3'd1);
    do_alloc(8'd40, {16'h0700, 32'h7777_0000, 4'd8}, 2);

    // Commit below oldest has no effect
    pulse_commit(8'd5);
    tick(); tick();
    chk(req_valid == 1'b0, "R4 stale commit ignored", req_valid, 0);
    pulse_commit(8'd40);
    tick();
    chk(req_valid == 1'b1 && req_idx == 3'd2, "R4 R5 late commit sends", req_idx, 2);
    tick();
    pulse_ack(3'd2);
    tick();
    chk(free_slots == 3'd4, "R8 empty again", free_slots, 4);

    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule